// File: doc/BRIEF.md
# Addressable Serial Attenuation Word Receiver

This block takes a three-wire serial control stream (data, shift clock and latch strobe) and turns it into attenuation settings for a step attenuator's state manager. A faster system clock samples the three pins. The block clocks frames of 16 bits into a shift register. When the latch strobe rises, it checks whether the frame is addressed to this device and, if so, issues the carried 7-bit attenuation code together with a one-cycle load strobe.

Each frame begins with the attenuation byte and ends with the address byte, and each byte arrives least significant bit first. The block compares only the three low address bits with three static address pins, so up to eight receivers can share one bus. A frame whose attenuation byte has its top bit set is not applied; instead it produces a one-cycle error pulse. The pins reach the block as clean digital levels, and it performs no electrical or pin-timing checks.

Top module: `atten_serial_rx`

## Requirements
- R1: After reset, `atten_o` is 7'h7F (maximum attenuation), and `load_o` and `err_o` are low.
- R2: A rising edge on `sclk_i` while `latch_i` is low shifts `sdata_i` into the frame register at bit 15 and moves the older bits toward bit 0. After 16 shifts, the first bit sent sits at bit 0. Bits 7..0 form the attenuation byte and bits 15..8 form the address byte.
- R3: Only frame bits 10..8 are compared with `addr_pins_i[2:0]`. Frame bits 15..11 have no effect on the decision.
- R4: On a rising edge of `latch_i`, if the address matches and frame bit 7 is 0, `load_o` is high for exactly one cycle. In that same cycle `atten_o` takes frame bits 6..0 and holds that value until the next load.
- R5: On a latch rising edge with an address mismatch, `load_o` and `err_o` stay low and `atten_o` is unchanged.
- R6: On a latch rising edge with a matching address and frame bit 7 set to 1, `err_o` is high for one cycle, `load_o` stays low and `atten_o` is unchanged.
- R7: Shift-clock rising edges while `latch_i` is high do not change the frame register, so a later latch edge with no shifts in between re-applies the same frame.
- R8: A latch rising edge that follows fewer than 16 shifts decodes whatever the frame register holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sdata_i | input | 1 | Serial data pin |
| sclk_i | input | 1 | Serial shift clock pin |
| latch_i | input | 1 | Latch strobe pin; shifting is allowed only while it is low |
| addr_pins_i | input | 3 | Static device address |
| load_o | output | 1 | One-cycle strobe: new attenuation code is valid |
| atten_o | output | 7 | Applied attenuation code, in quarter-dB units |
| err_o | output | 1 | One-cycle pulse: addressed frame had bit 7 set |

## Verification
The bench sends a frame whose upper address bits are junk while the low three bits match. A design that compared the whole address byte would drop this frame. It sends a matching frame with bit 7 set; a design that ignored the guard bit would apply code 0x05 instead of pulsing the error flag. It pulses the shift clock while the latch is high and then re-latches; a design that shifted in that state would corrupt the frame. Finally it latches after only four shifts, where a design that insisted on a complete count, or that cleared the register between frames, would disagree with a model of the bare shift register.

// File: rtl/atten_rx_pkg.sv
package atten_rx_pkg;
    // Frame geometry shared by the receiver modules.
    localparam int FRAME_BITS = 16;
    localparam int BYTE_BITS  = 8;
    localparam int ADDR_BITS  = 3;
    localparam int CODE_BITS  = BYTE_BITS - 1;

    // Outcome of decoding a latched frame.
    typedef enum logic [1:0] {
        DEC_IGNORE = 2'b00,
        DEC_APPLY  = 2'b01,
        DEC_REJECT = 2'b10
    } dec_t;
endpackage

// File: rtl/pin_sync.sv
// pin_sync: multi-stage synchronizer for WIDTH asynchronous pins, with a
// rising-edge flag per pin. Assumes pins are slow relative to clk.
module pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        logic              prev;

        // Shift the pin through the synchronizer chain and keep one older copy.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '0;
                prev  <= 1'b0;
            end else begin
                chain <= {chain[STAGES-2:0], pin_i[b]};
                prev  <= chain[STAGES-1];
            end
        end

        assign lvl_o[b]  = chain[STAGES-1];
        assign rise_o[b] = chain[STAGES-1] & ~prev;
    end
endmodule

// File: rtl/frame_shifter.sv
// frame_shifter: LSB-first serial-in register. Each shift enters at the top
// and moves the older bits toward bit 0. Assumes shift_i is a one-cycle flag.
module frame_shifter #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    // Advance the register on each qualified shift flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frame_o <= '0;
        else if (shift_i)
            frame_o <= {bit_i, frame_o[FRAME_W-1:1]};
    end
endmodule

// File: rtl/frame_decoder.sv
// frame_decoder: on a latch strobe, checks the low address bits and the guard
// bit of the attenuation byte, then applies the code or flags an error.
// Assumes frame_i is stable in the strobe cycle.
module frame_decoder
    import atten_rx_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADR_W  = 3,
    localparam int CODE_W = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [2*BYTE_W-1:0] frame_i,
    input  logic [ADR_W-1:0]  pins_i,
    output logic              load_o,
    output logic [CODE_W-1:0] code_o,
    output logic              err_o
);
    dec_t verdict;

    // Classify the current frame contents.
    always_comb begin
        if (frame_i[BYTE_W +: ADR_W] != pins_i)
            verdict = DEC_IGNORE;
        else if (frame_i[BYTE_W-1])
            verdict = DEC_REJECT;
        else
            verdict = DEC_APPLY;
    end

    // Register the outcome; the code resets to maximum attenuation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_o <= 1'b0;
            err_o  <= 1'b0;
            code_o <= '1;
        end else begin
            load_o <= strobe_i && (verdict == DEC_APPLY);
            err_o  <= strobe_i && (verdict == DEC_REJECT);
            if (strobe_i && verdict == DEC_APPLY)
                code_o <= frame_i[CODE_W-1:0];
        end
    end
endmodule

// File: rtl/atten_serial_rx.sv
// atten_serial_rx: addressable serial attenuation receiver. Synchronizes the
// three serial pins, shifts frames while latch is low and decodes them on the
// latch rising edge. Assumes latch is low while reset is released.
module atten_serial_rx
    import atten_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdata_i,
    input  logic                 sclk_i,
    input  logic                 latch_i,
    input  logic [ADDR_BITS-1:0] addr_pins_i,
    output logic                 load_o,
    output logic [CODE_BITS-1:0] atten_o,
    output logic                 err_o
);
    localparam int IDX_DATA  = 0;
    localparam int IDX_SCLK  = 1;
    localparam int IDX_LATCH = 2;

    logic [2:0]            pin_lvl;
    logic [2:0]            pin_rise;
    logic                  shift_en;
    logic                  latch_lvl;
    logic                  latch_rise;
    logic [FRAME_BITS-1:0] frame_q;

    pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({latch_i, sclk_i, sdata_i}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise)
    );

    assign latch_lvl  = pin_lvl[IDX_LATCH];
    assign latch_rise = pin_rise[IDX_LATCH];
    assign shift_en   = pin_rise[IDX_SCLK] & ~latch_lvl;

    frame_shifter #(.FRAME_W(FRAME_BITS)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_en),
        .bit_i   (pin_lvl[IDX_DATA]),
        .frame_o (frame_q)
    );

    frame_decoder #(.BYTE_W(BYTE_BITS), .ADR_W(ADDR_BITS)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (latch_rise),
        .frame_i  (frame_q),
        .pins_i   (addr_pins_i),
        .load_o   (load_o),
        .code_o   (atten_o),
        .err_o    (err_o)
    );
endmodule

// File: rtl/atten_serial_rx_chk.sv
// atten_serial_rx_chk: property checker bound into atten_serial_rx.
module atten_serial_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        load_o,
    input logic        err_o,
    input logic [6:0]  atten_o,
    input logic        latch_lvl,
    input logic [15:0] frame_q
);
    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o); // R4
    AST_CODE_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> (atten_o == $past(frame_q[6:0]) && !$past(frame_q[7]))); // R4
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(atten_o) |-> load_o); // R5
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!load_o && $past(frame_q[7]))); // R6
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R6
    AST_NO_SHIFT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        latch_lvl |=> $stable(frame_q)); // R7
endmodule

bind atten_serial_rx atten_serial_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_o    (load_o),
    .err_o     (err_o),
    .atten_o   (atten_o),
    .latch_lvl (latch_lvl),
    .frame_q   (frame_q)
);

// File: tb/atten_serial_rx_bench.sv
module atten_serial_rx_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sdata = 1'b0, sclk = 1'b0, latch = 1'b0;
    logic [2:0] pins = 3'b011;
    logic       load_o, err_o;
    logic [6:0] atten_o;

    int checks = 0, failures = 0;
    int loads = 0, errs = 0;
    logic [15:0] model = '0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    atten_serial_rx u_atten_serial_rx (
        .clk(clk), .rst_n(rst_n), .sdata_i(sdata), .sclk_i(sclk),
        .latch_i(latch), .addr_pins_i(pins),
        .load_o(load_o), .atten_o(atten_o), .err_o(err_o)
    );

    // Count output pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && load_o) loads++;
        if (rst_n && err_o)  errs++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(logic b);
        sdata = b;
        wait_cyc(3);
        sclk = 1'b1;
        wait_cyc(3);
        sclk = 1'b0;
        wait_cyc(3);
        if (!latch) model = {b, model[15:1]};
    endtask

    task automatic send_frame(logic [7:0] adr, logic [7:0] att);
        for (int i = 0; i < 8; i++) send_bit(att[i]);
        for (int i = 0; i < 8; i++) send_bit(adr[i]);
    endtask

    task automatic pulse_latch();
        latch = 1'b1;
        wait_cyc(6);
        latch = 1'b0;
        wait_cyc(6);
    endtask

    // Latch and compare against the expected outcome.
    task automatic latch_expect(string req, int exp_load, int exp_err, int exp_code);
        int l0 = loads;
        int e0 = errs;
        pulse_latch();
        check(req, loads - l0, exp_load);
        check(req, errs - e0, exp_err);
        check(req, atten_o, exp_code);
    endtask

    task automatic t_reset();
        check("R1", atten_o, 7'h7F);
        check("R1", load_o, 0);
        check("R1", err_o, 0);
    endtask

    task automatic t_match();
        send_frame(8'hFB, 8'h49);  // R2: upper address bits junk, low 011
        latch_expect("R2", 1, 0, 7'h49);
    endtask

    task automatic t_mismatch();
        send_frame(8'h05, 8'h22);
        latch_expect("R5", 0, 0, 7'h49);
    endtask

    task automatic t_upper_ignored();
        send_frame(8'h03, 8'h10);
        latch_expect("R3", 1, 0, 7'h10);
    endtask

    task automatic t_guard_bit();
        send_frame(8'h03, 8'h85);
        latch_expect("R6", 0, 1, 7'h10);
    endtask

    task automatic t_new_pins();
        pins = 3'b101;
        wait_cyc(4);
        send_frame(8'h05, 8'h7F);
        latch_expect("R4", 1, 0, 7'h7F);
        send_frame(8'h05, 8'h00);
        latch_expect("R4", 1, 0, 7'h00);
        send_frame(8'h05, 8'h7F);
        latch_expect("R4", 1, 0, 7'h7F);
    endtask

    task automatic t_latched_shift();
        latch = 1'b1;
        wait_cyc(6);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        latch = 1'b0;
        wait_cyc(6);
        latch_expect("R7", 1, 0, 7'h7F);
    endtask

    task automatic t_short_frame();
        // model now 0x057F; four zeros give 0x0057, address 000
        pins = 3'b000;
        wait_cyc(4);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        check("R8", model, 16'h0057);
        latch_expect("R8", 1, 0, 7'h57);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_match();
        t_mismatch();
        t_upper_ignored();
        t_guard_bit();
        t_new_pins();
        t_latched_shift();
        t_short_frame();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule